// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register File

This block is the host-visible register set of one bus-master disk DMA channel. The host reaches it through a plain register port: an address, a write strobe and a write data word, with combinational read data. It holds three registers. The control register carries the run/stop bit and the transfer direction. The status register mixes a live engine-activity bit, two sticky event flags that software clears by writing ones, and two per-drive capability flags. The third register is the descriptor-table base pointer.

The DMA engine consumes the run, direction and table base outputs. It reports activity as a level. It reports errors and completions as one-cycle pulses, and these set the sticky flags. The interrupt output follows the completion flag. A separate output reports whether the status shows a clean finish, which means completion set with activity and error both clear.

Top module: `dma_bm_regs`

## Requirements
- R1: After synchronous reset, every register reads zero, and `eng_run`, `eng_to_mem`, `table_base`, `irq` and `clean_end` are all low.
- R2: Control register (offset 0), bit 0 is run. A write sets `eng_run` to the written bit from the next cycle on, and bit 0 reads back that value.
- R3: Control register bit 3 is the direction bit (1 = transfer into memory). It drives `eng_to_mem` and reads back. All other control bits, and bits 31..8 of the control and status registers, read zero.
- R4: While `eng_active` is high, a write to the control register updates only the run bit. The direction bit keeps its value.
- R5: Status register (offset 2), bit 0 reads the current level of `eng_active` in the same cycle. Writes to this bit have no effect.
- R6: Status bit 1 (error) is set by an `eng_error` pulse. It is cleared by writing 1 to bit 1, and writing 0 to bit 1 leaves it unchanged.
- R7: Status bit 2 (interrupt) is set by an `eng_done` pulse. It is cleared by writing 1 to bit 2, and writing 0 leaves it unchanged. `irq` equals this bit.
- R8: When an engine event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R9: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Status bits 3, 4 and 7 read zero.
- R10: Table pointer register (offset 4) holds 32 bits. Bits 1..0 are forced to zero. It drives `table_base` and reads back the same value.
- R11: `clean_end` is high exactly when status bits 2..0 equal 100b.
- R12: Offsets other than 0, 2 and 4 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register byte offset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| eng_active | input | 1 | Engine is moving data (level) |
| eng_error | input | 1 | Engine error event (pulse) |
| eng_done | input | 1 | Engine completion event (pulse) |
| eng_run | output | 1 | Run command to the engine |
| eng_to_mem | output | 1 | Direction: 1 = write into memory |
| table_base | output | 32 | Descriptor table base address |
| irq | output | 1 | Interrupt, level of the completion flag |
| clean_end | output | 1 | Status shows a clean finish |

## Verification
The checker watches several rules on every cycle. It checks that the run bit follows each control write, that direction holds across writes made while the engine is active, and that a completion pulse always leaves the interrupt set, even against a same-cycle clear. It also checks that the interrupt rises only after a completion pulse, that the activity bit tracks the engine live, that unmapped offsets read zero and that `clean_end` never shows with activity or without the interrupt. Only the bench's sweeps can show that the write-one-to-clear semantics and the capability bits hold for every written byte in every flag state, that reserved bits stay zero, and that unmapped writes leave stored registers untouched.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int PTR_W      = 32;
    localparam int PTR_ZERO_W = 2;
    localparam int NUM_DRIVES = 2;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_PTR  = 3'd4;

    // control bit positions
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_DIR_BIT = 3;

    // status bit positions
    localparam int ST_ACT_BIT  = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_IRQ_BIT  = 2;
    localparam int ST_CAP_BASE = 5;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_PTR
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic to_mem;
    } ctrl_t;

    typedef struct packed {
        logic                  err;
        logic                  irq;
        logic [NUM_DRIVES-1:0] cap;
    } stat_t;

    function automatic reg_sel_e decode_ofs(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_PTR:  s = SEL_PTR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] ctrl_byte(ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CTRL_RUN_BIT] = c.run;
        b[CTRL_DIR_BIT] = c.to_mem;
        return b;
    endfunction

    function automatic logic [7:0] stat_byte(stat_t s, logic act);
        logic [7:0] b;
        b = '0;
        b[ST_ACT_BIT] = act;
        b[ST_ERR_BIT] = s.err;
        b[ST_IRQ_BIT] = s.irq;
        for (int d = 0; d < NUM_DRIVES; d++) begin
            b[ST_CAP_BASE + d] = s.cap[d];
        end
        return b;
    endfunction

    function automatic logic is_clean(logic [2:0] low3);
        return low3 == 3'b100;
    endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_bm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_run,
    input  logic  wr_dir,
    input  logic  eng_busy,
    output ctrl_t q
);

    ctrl_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (wr_en) begin
            q_r.run <= wr_run;
            if (!eng_busy) begin
                q_r.to_mem <= wr_dir;
            end
        end
    end

    assign q = q_r;

endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
    import dma_bm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  clr_err,
    input  logic                  clr_irq,
    input  logic [NUM_DRIVES-1:0] wr_cap,
    input  logic                  ev_err,
    input  logic                  ev_done,
    output stat_t                 q
);

    logic                  err_q;
    logic                  irq_q;
    logic [NUM_DRIVES-1:0] cap_q;

    // event has priority over a write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (ev_err) begin
            err_q <= 1'b1;
        end else if (wr_en && clr_err) begin
            err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (ev_done) begin
            irq_q <= 1'b1;
        end else if (wr_en && clr_irq) begin
            irq_q <= 1'b0;
        end
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_cap
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (wr_en) begin
                bit_q <= wr_cap[d];
            end
        end
        assign cap_q[d] = bit_q;
    end

    assign q.err = err_q;
    assign q.irq = irq_q;
    assign q.cap = cap_q;

endmodule

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
    parameter int PTR_W      = 32,
    parameter int PTR_ZERO_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PTR_W-1:PTR_ZERO_W]  wr_hi,
    output logic [PTR_W-1:0]           q
);

    logic [PTR_W-1:PTR_ZERO_W] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (wr_en) begin
            hi_q <= wr_hi;
        end
    end

    assign q = {hi_q, {PTR_ZERO_W{1'b0}}};

endmodule

// File: rtl/dma_bm_regs.sv
module dma_bm_regs
    import dma_bm_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W,
    parameter int P_W = PTR_W,
    parameter int Z_W = PTR_ZERO_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] host_addr,
    input  logic           host_wr,
    input  logic [D_W-1:0] host_wdata,
    output logic [D_W-1:0] host_rdata,
    input  logic           eng_active,
    input  logic           eng_error,
    input  logic           eng_done,
    output logic           eng_run,
    output logic           eng_to_mem,
    output logic [P_W-1:0] table_base,
    output logic           irq,
    output logic           clean_end
);

    localparam int CAP_HI = ST_CAP_BASE + NUM_DRIVES - 1;

    reg_sel_e   sel;
    ctrl_t      ctrl;
    stat_t      stat;
    logic [7:0] stat_view;

    assign sel = decode_ofs(host_addr);

    dma_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr && sel == SEL_CTRL),
        .wr_run   (host_wdata[CTRL_RUN_BIT]),
        .wr_dir   (host_wdata[CTRL_DIR_BIT]),
        .eng_busy (eng_active),
        .q        (ctrl)
    );

    dma_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr && sel == SEL_STAT),
        .clr_err (host_wdata[ST_ERR_BIT]),
        .clr_irq (host_wdata[ST_IRQ_BIT]),
        .wr_cap  (host_wdata[CAP_HI:ST_CAP_BASE]),
        .ev_err  (eng_error),
        .ev_done (eng_done),
        .q       (stat)
    );

    dma_ptr_reg #(
        .PTR_W      (P_W),
        .PTR_ZERO_W (Z_W)
    ) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (host_wr && sel == SEL_PTR),
        .wr_hi (host_wdata[P_W-1:Z_W]),
        .q     (table_base)
    );

    assign stat_view = stat_byte(stat, eng_active);

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_CTRL: host_rdata[7:0]     = ctrl_byte(ctrl);
            SEL_STAT: host_rdata[7:0]     = stat_view;
            SEL_PTR:  host_rdata[P_W-1:0] = table_base;
            default:  host_rdata = '0;
        endcase
    end

    assign eng_run    = ctrl.run;
    assign eng_to_mem = ctrl.to_mem;
    assign irq        = stat.irq;
    assign clean_end  = is_clean(stat_view[2:0]);

endmodule

// File: rtl/dma_bm_regs_chk.sv
module dma_bm_regs_chk
    import dma_bm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              wr_bit0,
    input logic [DATA_W-1:0] host_rdata,
    input logic              eng_active,
    input logic              eng_done,
    input logic              eng_run,
    input logic              eng_to_mem,
    input logic [PTR_W-1:0]  table_base,
    input logic              irq,
    input logic              clean_end
);

    // R2
    run_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_CTRL) |=> (eng_run == $past(wr_bit0)));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && eng_active && host_addr == OFS_CTRL) |=> $stable(eng_to_mem));

    // R5
    act_view_chk: assert property (@(posedge clk) disable iff (rst)
        (host_addr == OFS_STAT) |-> (host_rdata[ST_ACT_BIT] == eng_active));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eng_done));

    // R8
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq);

    // R10
    ptr_view_chk: assert property (@(posedge clk) disable iff (rst)
        (host_addr == OFS_PTR) |-> (host_rdata == table_base));

    // R11
    clean_end_chk: assert property (@(posedge clk) disable iff (rst)
        clean_end |-> (irq && !eng_active));

    // R12
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (host_addr != OFS_CTRL && host_addr != OFS_STAT && host_addr != OFS_PTR)
        |-> (host_rdata == '0));

endmodule

bind dma_bm_regs dma_bm_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .wr_bit0    (host_wdata[0]),
    .host_rdata (host_rdata),
    .eng_active (eng_active),
    .eng_done   (eng_done),
    .eng_run    (eng_run),
    .eng_to_mem (eng_to_mem),
    .table_base (table_base),
    .irq        (irq),
    .clean_end  (clean_end)
);

// File: tb/dma_bm_regs_test.sv
module dma_bm_regs_test;
    import dma_bm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_active = 1'b0;
    logic        eng_error = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_run;
    logic        eng_to_mem;
    logic [31:0] table_base;
    logic        irq;
    logic        clean_end;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_bm_regs uut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_active (eng_active),
        .eng_error  (eng_error),
        .eng_done   (eng_done),
        .eng_run    (eng_run),
        .eng_to_mem (eng_to_mem),
        .table_base (table_base),
        .irq        (irq),
        .clean_end  (clean_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic pulse(input logic e, input logic dn);
        @(negedge clk);
        eng_error = e;
        eng_done  = dn;
        @(negedge clk);
        eng_error = 1'b0;
        eng_done  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 read", v, 32'h0);
        end
        check("R1 outputs", {27'h0, eng_run, eng_to_mem, irq, clean_end, |table_base}, 32'h0);

        // R2 R3 control sweep with engine idle
        for (int b = 0; b < 256; b++) begin
            wr(OFS_CTRL, {4{b[7:0]}});
            rd(OFS_CTRL, v);
            check("R3 ctrl readback", v, {24'h0, b[7:0] & 8'h09});
            check("R2 run out", {31'h0, eng_run}, {31'h0, b[0]});
            check("R3 dir out", {31'h0, eng_to_mem}, {31'h0, b[3]});
        end

        // R4 R5 direction frozen while active
        wr(OFS_CTRL, 32'h0);
        @(negedge clk);
        eng_active = 1'b1;
        rd(OFS_STAT, v);
        check("R5 active view", v & 32'h1, 32'h1);
        wr(OFS_CTRL, 32'h09);
        rd(OFS_CTRL, v);
        check("R4 dir ignored", v, 32'h01);
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, v);
        check("R5 act not writable", v & 32'h1, 32'h1);
        eng_active = 1'b0;
        rd(OFS_STAT, v);
        check("R5 idle view", v & 32'h1, 32'h0);
        wr(OFS_CTRL, 32'h08);
        rd(OFS_CTRL, v);
        check("R4 dir after idle", v, 32'h08);

        // R6 R7 R9 R11 status sweep over flag states and write bytes
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 256; b++) begin
                wr(OFS_STAT, 32'h06);
                pulse(s[0], s[1]);
                wr(OFS_STAT, {24'hFF_FF_FF, b[7:0]});
                exp = 32'h0;
                exp[1] = s[0] & ~b[1];
                exp[2] = s[1] & ~b[2];
                exp[6:5] = b[6:5];
                rd(OFS_STAT, v);
                check("R6 R7 R9 status", v, exp);
                check("R7 irq out", {31'h0, irq}, {31'h0, exp[2]});
                check("R11 clean", {31'h0, clean_end},
                      {31'h0, exp[2:0] == 3'b100});
            end
        end

        // R8 event beats same-cycle clear
        wr(OFS_STAT, 32'h06);
        @(negedge clk);
        eng_done = 1'b1; eng_error = 1'b1;
        host_addr = OFS_STAT; host_wdata = 32'h06; host_wr = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_error = 1'b0; host_wr = 1'b0;
        rd(OFS_STAT, v);
        check("R8 set wins", v, 32'h06);

        // R10 pointer walking ones
        for (int i = 0; i < 32; i++) begin
            wr(OFS_PTR, 32'h1 << i);
            rd(OFS_PTR, v);
            exp = (32'h1 << i) & 32'hFFFF_FFFC;
            check("R10 ptr read", v, exp);
            check("R10 ptr out", table_base, exp);
        end

        // R12 unmapped offsets
        wr(OFS_PTR, 32'h1234_5677);
        wr(OFS_CTRL, 32'h09);
        wr(OFS_STAT, 32'h66);
        for (int a = 0; a < 8; a++) begin
            if (a == 0 || a == 2 || a == 4) continue;
            wr(a[2:0], 32'hFFFF_FFFF);
            rd(a[2:0], v);
            check("R12 unmapped read", v, 32'h0);
        end
        rd(OFS_CTRL, v);
        check("R12 ctrl kept", v, 32'h09);
        rd(OFS_STAT, v);
        check("R12 stat kept", v, 32'h60);
        rd(OFS_PTR, v);
        check("R12 ptr kept", v, 32'h1234_5674);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule